// File: doc/BRIEF.md
# SCSI Command Descriptor Responder

This block plays the target side of a small storage controller. A host presents a command descriptor block as a parallel byte vector, together with a destination byte whose low three bits name the target. The host pulses a start strobe. In the same cycle the block decodes the opcode and checks whether the target exists. It then loads the outcome: a transfer length and direction, an optional response payload, and a three-byte completion code made of a status byte, an interrupt byte and a sequence step. It also raises an interrupt line.

Inquiry and read-capacity payloads are built inside the block. The host reads them one byte at a time through a byte-address port. Read(10) and write(10) do not move data here. They emit a one-cycle storage request that carries the block address, the block count and a read flag, so an external media or DMA engine can act on it. The interrupt stays raised until the host pulses the clear input.

Top module: `cdb_responder`

## Requirements
- R1: A one-cycle pulse on `cdb_valid_i` is taken at the clock edge. All results are visible from the next cycle, and `irq_o` is 1 from that cycle.
- R2: The block treats a target as absent when `dest_i[2:0]` is greater than 4 or its bit in `present_i` is 0. A command to an absent target completes with status 0x80, interrupt 0x20 and sequence 0. It sets transfer length 0 and `xfer_dir_o` 0, raises no storage request and leaves the response buffer unchanged.
- R3: A command to a present target completes with status 0x91, interrupt 0x18 and sequence 4, whatever its opcode.
- R4: The opcode is descriptor byte 1 (`cdb_i[15:8]`). Inquiry (0x12) loads a 36-byte response, with transfer length 36 and `xfer_dir_o` 1 (device to host). Byte 0 is 5 if the target's `optical_i` bit is 1 and 0 otherwise. Byte 2 is 1 and byte 3 is 2. Bytes 8..15 hold the vendor text and bytes 16..31 hold the product text, either the disk text or the optical text. Every other byte reads 0.
- R5: Read capacity (0x25) loads an 8-byte response, with transfer length 8 and `xfer_dir_o` 1. Bytes 0..3 hold `sector_cnt_i`, most significant byte first. Bytes 4..7 are 00 00 02 00.
- R6: Read(10) (0x28) and write(10) (0x2A) take the block address from descriptor bytes 3..6 and the block count from bytes 8..9, both big-endian. Transfer length is count×512. `xfer_dir_o` and `sreq_rd_o` are 1 for read and 0 for write.
- R7: Test unit ready (0x00), mode sense(6) (0x1A) and any unsupported opcode complete with transfer length 0 and `xfer_dir_o` 0. They raise no storage request and leave the response buffer unchanged.
- R8: `sreq_valid_o` is high for exactly the one cycle after a read(10) or write(10) to a present target, and it is never high otherwise.
- R9: `irq_o` stays 1 until `irq_clr_i` is seen at a clock edge with no new command. A command in the same cycle as a clear leaves `irq_o` at 1.
- R10: After reset, status, interrupt and sequence read 0, `irq_o` is 0, transfer length is 0 and every response byte reads 0.
- R11: Bits 7..3 of `dest_i` have no effect on target selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cdb_valid_i | input | 1 | Start strobe, one cycle per command |
| cdb_i | input | CDB_BYTES*8 | Descriptor, byte k at bits 8k+7..8k |
| dest_i | input | 8 | Destination byte; low 3 bits select the target |
| present_i | input | NUM_TARGETS | Per-target presence mask |
| optical_i | input | NUM_TARGETS | Per-target device kind, 1 = optical |
| sector_cnt_i | input | 32 | Sector count of the addressed target |
| irq_clr_i | input | 1 | Interrupt clear pulse |
| resp_addr_i | input | ADDR_W | Response byte address |
| resp_data_o | output | 8 | Response byte at resp_addr_i |
| xfer_len_o | output | 25 | Transfer length in bytes |
| xfer_dir_o | output | 1 | 1 = device to host |
| sreq_valid_o | output | 1 | Storage request pulse |
| sreq_lba_o | output | 32 | Requested block address |
| sreq_cnt_o | output | 16 | Requested block count |
| sreq_rd_o | output | 1 | 1 = read, 0 = write |
| status_o | output | 8 | Completion status byte |
| intr_o | output | 8 | Completion interrupt byte |
| seq_o | output | 8 | Completion sequence step |
| irq_o | output | 1 | Sticky interrupt |

## Verification
Every opcode class is sent to a present disk target and to a present optical target. This separates the two inquiry product texts and the device-type byte. Read and write use different addresses and counts, and they tell apart byte order, direction and the ×512 scaling. Commands with no data run after a capacity load, which shows that the buffer is kept. Absent targets are tried both above the index limit and through a cleared presence bit. A clear that collides with a command shows which of the two wins.

// File: rtl/cdb_pkg.sv
package cdb_pkg;
  localparam int LBA_W     = 32;
  localparam int CNT_W     = 16;
  localparam int BLK_SHIFT = 9;
  localparam int LEN_W     = CNT_W + BLK_SHIFT;
  localparam int TGT_W     = 3;
  localparam int TGT_SLOTS = 1 << TGT_W;

  localparam logic [7:0] OPC_TUR  = 8'h00;
  localparam logic [7:0] OPC_INQ  = 8'h12;
  localparam logic [7:0] OPC_MSNS = 8'h1A;
  localparam logic [7:0] OPC_CAP  = 8'h25;
  localparam logic [7:0] OPC_RD   = 8'h28;
  localparam logic [7:0] OPC_WR   = 8'h2A;

  localparam logic [7:0] ST_OK     = 8'h91;
  localparam logic [7:0] IN_OK     = 8'h18;
  localparam logic [7:0] SQ_OK     = 8'h04;
  localparam logic [7:0] ST_ABSENT = 8'h80;
  localparam logic [7:0] IN_ABSENT = 8'h20;
  localparam logic [7:0] SQ_ABSENT = 8'h00;

  localparam int INQ_LEN = 36;
  localparam int CAP_LEN = 8;

  typedef enum logic [2:0] {
    OP_TUR, OP_INQ, OP_MSNS, OP_CAP, OP_RD, OP_WR, OP_OTHER
  } op_e;

  typedef enum logic [1:0] {
    BUF_EMPTY, BUF_INQ, BUF_CAP
  } buf_e;
endpackage

// File: rtl/cdb_decode.sv
module cdb_decode
  import cdb_pkg::*;
#(
  parameter int CDB_BYTES = 10
) (
  input  logic [CDB_BYTES*8-1:0] cdb_i,
  output op_e                    op_o,
  output logic [LBA_W-1:0]       lba_o,
  output logic [CNT_W-1:0]       cnt_o
);
  logic [7:0] byt [CDB_BYTES];

  for (genvar g = 0; g < CDB_BYTES; g++) begin : g_byte
    assign byt[g] = cdb_i[8*g +: 8];
  end

  assign lba_o = {byt[3], byt[4], byt[5], byt[6]};
  assign cnt_o = {byt[8], byt[9]};

  always_comb begin
    unique case (byt[1])
      OPC_TUR:  op_o = OP_TUR;
      OPC_INQ:  op_o = OP_INQ;
      OPC_MSNS: op_o = OP_MSNS;
      OPC_CAP:  op_o = OP_CAP;
      OPC_RD:   op_o = OP_RD;
      OPC_WR:   op_o = OP_WR;
      default:  op_o = OP_OTHER;
    endcase
  end
endmodule

// File: rtl/cdb_resp_buf.sv
module cdb_resp_buf
  import cdb_pkg::*;
#(
  parameter int           ADDR_W    = 6,
  parameter logic [63:0]  VENDOR    = "GENERIC ",
  parameter logic [127:0] PROD_DISK = "FIXED DISK      ",
  parameter logic [127:0] PROD_OPT  = "OPTICAL DRIVE   "
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_inq_i,
  input  logic              ld_cap_i,
  input  logic              optical_i,
  input  logic [31:0]       cap_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [7:0]        data_o
);
  buf_e        kind_q;
  logic        opt_q;
  logic [31:0] cap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      kind_q <= BUF_EMPTY;
      opt_q  <= 1'b0;
      cap_q  <= '0;
    end else if (ld_inq_i) begin
      kind_q <= BUF_INQ;
      opt_q  <= optical_i;
    end else if (ld_cap_i) begin
      kind_q <= BUF_CAP;
      cap_q  <= cap_i;
    end
  end

  int a;
  logic [127:0] prod;
  assign a    = int'(addr_i);
  assign prod = opt_q ? PROD_OPT : PROD_DISK;

  always_comb begin
    data_o = 8'h00;
    unique case (kind_q)
      BUF_INQ: begin
        if (a == 0)                 data_o = opt_q ? 8'd5 : 8'd0;
        else if (a == 2)            data_o = 8'd1;
        else if (a == 3)            data_o = 8'd2;
        else if (a >= 8 && a < 16)  data_o = VENDOR[8*(15-a) +: 8];
        else if (a >= 16 && a < 32) data_o = prod[8*(31-a) +: 8];
      end
      BUF_CAP: begin
        if (a < 4)       data_o = cap_q[8*(3-a) +: 8];
        else if (a == 6) data_o = 8'h02;
      end
      default: data_o = 8'h00;
    endcase
  end
endmodule

// File: rtl/cdb_status.sv
module cdb_status
  import cdb_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       go_i,
  input  logic       present_i,
  input  logic       clr_i,
  output logic [7:0] status_o,
  output logic [7:0] intr_o,
  output logic [7:0] seq_o,
  output logic       irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_o <= '0;
      intr_o   <= '0;
      seq_o    <= '0;
      irq_o    <= 1'b0;
    end else if (go_i) begin
      status_o <= present_i ? ST_OK : ST_ABSENT;
      intr_o   <= present_i ? IN_OK : IN_ABSENT;
      seq_o    <= present_i ? SQ_OK : SQ_ABSENT;
      irq_o    <= 1'b1;
    end else if (clr_i) begin
      irq_o    <= 1'b0;
    end
  end
endmodule

// File: rtl/cdb_responder.sv
module cdb_responder
  import cdb_pkg::*;
#(
  parameter int           CDB_BYTES   = 10,
  parameter int           NUM_TARGETS = 5,
  parameter int           ADDR_W      = 6,
  parameter logic [63:0]  VENDOR      = "GENERIC ",
  parameter logic [127:0] PROD_DISK   = "FIXED DISK      ",
  parameter logic [127:0] PROD_OPT    = "OPTICAL DRIVE   "
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   cdb_valid_i,
  input  logic [CDB_BYTES*8-1:0] cdb_i,
  input  logic [7:0]             dest_i,
  input  logic [NUM_TARGETS-1:0] present_i,
  input  logic [NUM_TARGETS-1:0] optical_i,
  input  logic [31:0]            sector_cnt_i,
  input  logic                   irq_clr_i,
  input  logic [ADDR_W-1:0]      resp_addr_i,
  output logic [7:0]             resp_data_o,
  output logic [LEN_W-1:0]       xfer_len_o,
  output logic                   xfer_dir_o,
  output logic                   sreq_valid_o,
  output logic [LBA_W-1:0]       sreq_lba_o,
  output logic [CNT_W-1:0]       sreq_cnt_o,
  output logic                   sreq_rd_o,
  output logic [7:0]             status_o,
  output logic [7:0]             intr_o,
  output logic [7:0]             seq_o,
  output logic                   irq_o
);
  localparam int PAD = TGT_SLOTS - NUM_TARGETS;

  logic [TGT_W-1:0]     tgt;
  logic [TGT_SLOTS-1:0] pres_pad, opt_pad;
  logic                 tgt_ok;
  op_e                  op;
  logic [LBA_W-1:0]     lba;
  logic [CNT_W-1:0]     cnt;
  logic                 go_ok;

  assign tgt      = dest_i[TGT_W-1:0];
  assign pres_pad = {{PAD{1'b0}}, present_i};
  assign opt_pad  = {{PAD{1'b0}}, optical_i};
  assign tgt_ok   = pres_pad[tgt];
  assign go_ok    = cdb_valid_i && tgt_ok;

  cdb_decode #(.CDB_BYTES(CDB_BYTES)) u_dec (
    .cdb_i (cdb_i),
    .op_o  (op),
    .lba_o (lba),
    .cnt_o (cnt)
  );

  cdb_resp_buf #(
    .ADDR_W(ADDR_W), .VENDOR(VENDOR), .PROD_DISK(PROD_DISK), .PROD_OPT(PROD_OPT)
  ) u_buf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ld_inq_i  (go_ok && op == OP_INQ),
    .ld_cap_i  (go_ok && op == OP_CAP),
    .optical_i (opt_pad[tgt]),
    .cap_i     (sector_cnt_i),
    .addr_i    (resp_addr_i),
    .data_o    (resp_data_o)
  );

  cdb_status u_st (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .go_i      (cdb_valid_i),
    .present_i (tgt_ok),
    .clr_i     (irq_clr_i),
    .status_o  (status_o),
    .intr_o    (intr_o),
    .seq_o     (seq_o),
    .irq_o     (irq_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      xfer_len_o   <= '0;
      xfer_dir_o   <= 1'b0;
      sreq_valid_o <= 1'b0;
      sreq_lba_o   <= '0;
      sreq_cnt_o   <= '0;
      sreq_rd_o    <= 1'b0;
    end else begin
      sreq_valid_o <= 1'b0;
      if (cdb_valid_i) begin
        // length and direction cleared before decode
        xfer_len_o <= '0;
        xfer_dir_o <= 1'b0;
        if (tgt_ok) begin
          unique case (op)
            OP_INQ: begin
              xfer_len_o <= LEN_W'(INQ_LEN);
              xfer_dir_o <= 1'b1;
            end
            OP_CAP: begin
              xfer_len_o <= LEN_W'(CAP_LEN);
              xfer_dir_o <= 1'b1;
            end
            OP_RD, OP_WR: begin
              xfer_len_o   <= {cnt, {BLK_SHIFT{1'b0}}};
              xfer_dir_o   <= (op == OP_RD);
              sreq_valid_o <= 1'b1;
              sreq_lba_o   <= lba;
              sreq_cnt_o   <= cnt;
              sreq_rd_o    <= (op == OP_RD);
            end
            default: ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/cdb_responder_chk.sv
module cdb_responder_chk
  import cdb_pkg::*;
#(
  parameter int NUM_TARGETS = 5
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   cdb_valid_i,
  input logic [7:0]             dest_i,
  input logic [NUM_TARGETS-1:0] present_i,
  input logic                   irq_clr_i,
  input logic [7:0]             status_o,
  input logic [7:0]             intr_o,
  input logic [7:0]             seq_o,
  input logic                   irq_o,
  input logic                   sreq_valid_o,
  input logic [CNT_W-1:0]       sreq_cnt_o,
  input logic [LEN_W-1:0]       xfer_len_o
);
  logic here;
  always_comb begin
    here = 1'b0;
    for (int i = 0; i < NUM_TARGETS; i++)
      if (int'(dest_i[2:0]) == i && present_i[i]) here = 1'b1;
  end

  a_r1_irq_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cdb_valid_i |=> irq_o);

  a_r2_absent_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cdb_valid_i && !here |=> status_o == 8'h80 && intr_o == 8'h20 && seq_o == 8'h00 && !sreq_valid_o);

  a_r3_present_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cdb_valid_i && here |=> status_o == 8'h91 && intr_o == 8'h18 && seq_o == 8'h04);

  a_r6_len_matches_cnt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sreq_valid_o |-> xfer_len_o == {sreq_cnt_o, 9'd0});

  a_r8_sreq_after_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sreq_valid_o |-> $past(cdb_valid_i));

  a_r9_irq_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && !irq_clr_i |=> irq_o);

  a_r9_irq_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_clr_i && !cdb_valid_i |=> !irq_o);
endmodule

bind cdb_responder cdb_responder_chk #(.NUM_TARGETS(NUM_TARGETS)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cdb_valid_i  (cdb_valid_i),
  .dest_i       (dest_i),
  .present_i    (present_i),
  .irq_clr_i    (irq_clr_i),
  .status_o     (status_o),
  .intr_o       (intr_o),
  .seq_o        (seq_o),
  .irq_o        (irq_o),
  .sreq_valid_o (sreq_valid_o),
  .sreq_cnt_o   (sreq_cnt_o),
  .xfer_len_o   (xfer_len_o)
);

// File: tb/sim_cdb_responder.sv
`timescale 1ns/1ps
module sim_cdb_responder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cdb_valid = 1'b0;
  logic [79:0] cdb = '0;
  logic [7:0]  dest = '0;
  logic [4:0]  present = 5'b01111;
  logic [4:0]  optical = 5'b00100;
  logic [31:0] sec_cnt = '0;
  logic        irq_clr = 1'b0;
  logic [5:0]  raddr = '0;
  logic [7:0]  rdata;
  logic [24:0] xlen;
  logic        xdir, sv, srd, irq;
  logic [31:0] slba;
  logic [15:0] scnt;
  logic [7:0]  st, it, sq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  cdb_responder u0 (
    .clk_i(clk), .rst_ni(rst_n), .cdb_valid_i(cdb_valid), .cdb_i(cdb), .dest_i(dest),
    .present_i(present), .optical_i(optical), .sector_cnt_i(sec_cnt), .irq_clr_i(irq_clr),
    .resp_addr_i(raddr), .resp_data_o(rdata), .xfer_len_o(xlen), .xfer_dir_o(xdir),
    .sreq_valid_o(sv), .sreq_lba_o(slba), .sreq_cnt_o(scnt), .sreq_rd_o(srd),
    .status_o(st), .intr_o(it), .seq_o(sq), .irq_o(irq)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [79:0] mk(logic [7:0] op, logic [31:0] lba, logic [15:0] cnt);
    logic [79:0] c = '0;
    c[15:8]  = op;
    c[31:24] = lba[31:24]; c[39:32] = lba[23:16];
    c[47:40] = lba[15:8];  c[55:48] = lba[7:0];
    c[71:64] = cnt[15:8];  c[79:72] = cnt[7:0];
    return c;
  endfunction

  task automatic rbyte(int a, output logic [7:0] d);
    raddr = 6'(a);
    #0.1;
    d = rdata;
  endtask

  // drives one command; returns at the negedge after the accepting edge
  task automatic issue(logic [7:0] d, logic [79:0] c);
    @(negedge clk);
    dest = d; cdb = c; cdb_valid = 1'b1;
    @(negedge clk);
    cdb_valid = 1'b0;
  endtask

  task automatic chk_code(string req, bit ok);
    chk(req, st, ok ? 32'h91 : 32'h80);
    chk(req, it, ok ? 32'h18 : 32'h20);
    chk(req, sq, ok ? 32'h04 : 32'h00);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R10 status", st, 0); chk("R10 intr", it, 0); chk("R10 seq", sq, 0);
    chk("R10 irq", irq, 0); chk("R10 len", xlen, 0); chk("R10 sreq", sv, 0);
    rbyte(0, d); chk("R10 resp0", d, 0);
  endtask

  task automatic t_inq_disk();
    logic [7:0] d;
    issue(8'h00, mk(8'h12, 0, 0));
    chk("R1 irq", irq, 1);
    chk_code("R3 inquiry", 1);
    chk("R4 len", xlen, 36); chk("R4 dir", xdir, 1);
    rbyte(0, d);  chk("R4 b0 disk", d, 0);
    rbyte(2, d);  chk("R4 b2", d, 1);
    rbyte(3, d);  chk("R4 b3", d, 2);
    rbyte(8, d);  chk("R4 vendor0", d, "G");
    rbyte(15, d); chk("R4 vendor7", d, " ");
    rbyte(16, d); chk("R4 product disk", d, "F");
    rbyte(35, d); chk("R4 b35", d, 0);
    rbyte(1, d);  chk("R4 b1", d, 0);
  endtask

  task automatic t_irq_clear();
    @(negedge clk); irq_clr = 1'b1;
    @(negedge clk); irq_clr = 1'b0;
    chk("R9 cleared", irq, 0);
    chk("R9 status kept", st, 32'h91);
  endtask

  task automatic t_inq_optical();
    logic [7:0] d;
    issue(8'hF2, mk(8'h12, 0, 0));
    chk_code("R11 upper dest bits", 1);
    rbyte(0, d);  chk("R4 b0 optical", d, 5);
    rbyte(16, d); chk("R4 product optical", d, "O");
    rbyte(31, d); chk("R4 product last", d, " ");
  endtask

  task automatic t_cap();
    logic [7:0] d;
    sec_cnt = 32'h1234_5678;
    issue(8'h01, mk(8'h25, 0, 0));
    sec_cnt = 32'hFFFF_FFFF;
    chk("R5 len", xlen, 8); chk("R5 dir", xdir, 1);
    rbyte(0, d); chk("R5 b0", d, 8'h12);
    rbyte(3, d); chk("R5 b3", d, 8'h78);
    rbyte(5, d); chk("R5 b5", d, 0);
    rbyte(6, d); chk("R5 b6", d, 2);
    rbyte(7, d); chk("R5 b7", d, 0);
  endtask

  task automatic t_read10();
    issue(8'h03, mk(8'h28, 32'hA1B2_C3D4, 16'd3));
    chk("R8 pulse", sv, 1);
    chk("R6 lba", slba, 32'hA1B2_C3D4); chk("R6 cnt", scnt, 3);
    chk("R6 rd", srd, 1); chk("R6 len", xlen, 1536); chk("R6 dir", xdir, 1);
    @(negedge clk);
    chk("R8 one cycle", sv, 0);
  endtask

  task automatic t_write10();
    issue(8'h00, mk(8'h2A, 32'h0000_0102, 16'h0100));
    chk("R8 pulse wr", sv, 1);
    chk("R6 lba wr", slba, 32'h102); chk("R6 cnt wr", scnt, 16'h100);
    chk("R6 wr flag", srd, 0); chk("R6 len wr", xlen, 131072); chk("R6 dir wr", xdir, 0);
  endtask

  task automatic t_nodata(logic [7:0] op, string tag);
    logic [7:0] d;
    sec_cnt = 32'h1234_5678;
    issue(8'h01, mk(8'h25, 0, 0));
    issue(8'h01, mk(op, 32'h55, 16'd9));
    chk({"R7 len ", tag}, xlen, 0); chk({"R7 dir ", tag}, xdir, 0);
    chk({"R7 sreq ", tag}, sv, 0);
    chk_code({"R3 ", tag}, 1);
    rbyte(3, d); chk({"R7 buffer kept ", tag}, d, 8'h78);
  endtask

  task automatic t_absent();
    logic [7:0] d;
    issue(8'h02, mk(8'h12, 0, 0));
    issue(8'h05, mk(8'h12, 0, 0));
    chk_code("R2 target 5", 0);
    chk("R2 len", xlen, 0); chk("R2 dir", xdir, 0);
    rbyte(0, d); chk("R2 buffer kept", d, 5);
    issue(8'h04, mk(8'h28, 32'h10, 16'd1));
    chk("R2 no sreq", sv, 0);
    chk_code("R2 target 4 masked", 0);
    issue(8'h07, mk(8'h25, 0, 0));
    chk_code("R2 target 7", 0);
  endtask

  task automatic t_clear_collide();
    @(negedge clk); irq_clr = 1'b1;
    @(negedge clk); irq_clr = 1'b0;
    chk("R9 cleared before", irq, 0);
    @(negedge clk);
    dest = 8'h00; cdb = mk(8'h00, 0, 0); cdb_valid = 1'b1; irq_clr = 1'b1;
    @(negedge clk);
    cdb_valid = 1'b0; irq_clr = 1'b0;
    chk("R9 command wins", irq, 1);
    @(negedge clk);
    chk("R9 still held", irq, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_inq_disk();
    t_irq_clear();
    t_inq_optical();
    t_cap();
    t_read10();
    t_write10();
    t_nodata(8'h00, "tur");
    t_nodata(8'h1A, "msense");
    t_nodata(8'h55, "unknown");
    t_absent();
    t_clear_collide();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule